// File: doc/BRIEF.md
# Windowed Circular Command Queue with Debug Peek

This block is one channel's command queue. Its entries live in a slice of a RAM that is marked out by a programmable first index and last index. Both indices are inclusive. Writes are made at the write pointer and reads are taken from the read pointer. Each pointer steps forward one entry per accepted access. After reaching the last index, a pointer returns to the first index.

A debug port sits beside the normal push and pop interface. It shows the live read and write pointers at all times. When it is enabled with this channel's number, it also returns the stored word at any chosen RAM index. A debug read never moves a pointer. Software can therefore walk the live entries from the read pointer up to the write pointer while the queue keeps working.

Loading new window bounds puts both pointers back at the new first index. Loading bounds is allowed only while the queue is empty.

Top module: `cmd_ring_fifo`

## Requirements
- R1: After reset, the window is 0 to DEPTH-1, both pointers are 0, `empty`=1, `full`=0, `pushReady`=1 and `peekData`=0.
- R2: A push with `pushReady`=1 stores `pushData` at the write pointer, and the write pointer steps forward at that clock edge. While not empty, `popData` shows the word at the read pointer, and a pop steps the read pointer forward at the edge.
- R3: A pointer that equals the last index becomes the first index on its next step. Pointers stay inside the window.
- R4: `empty` is 1 exactly when the read pointer equals the write pointer.
- R5: `full` is 1, and `pushReady` is 0, exactly when stepping the write pointer would make it equal the read pointer. A push while full stores nothing and moves nothing. The usable capacity is therefore last index minus first index. A one-entry window holds nothing.
- R6: A pop while empty leaves the read pointer unchanged.
- R7: With `peekEn`=1 and `peekChan` equal to parameter CHAN_ID, `peekData` shows the word stored at `peekAddr` one cycle later. In every other case, `peekData` becomes 0 one cycle later.
- R8: A debug read changes neither pointer nor the occupancy.
- R9: `cfgWrite` loads `cfgBase` and `cfgLimit` and sets both pointers to `cfgBase`. A push or pop in the same cycle is ignored. Loading bounds while not empty, or with the first index above the last, is illegal.
- R10: A push and a pop in the same cycle, while neither full nor empty, both take effect and leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Load window bounds and reset pointers |
| cfgBase | input | ADDR_W | First index of the window |
| cfgLimit | input | ADDR_W | Last index of the window (inclusive) |
| pushValid | input | 1 | Push request |
| pushData | input | DATA_W | Word to push |
| pushReady | output | 1 | Push would be accepted (not full) |
| popEn | input | 1 | Pop request |
| popData | output | DATA_W | Word at the read pointer |
| empty | output | 1 | Queue empty |
| full | output | 1 | Queue full |
| peekEn | input | 1 | Debug read enable |
| peekChan | input | CHAN_W | Channel number selected for the debug read |
| peekAddr | input | ADDR_W | RAM index to read |
| peekData | output | DATA_W | Registered debug read result |
| peekRdPtr | output | ADDR_W | Live read pointer |
| peekWrPtr | output | ADDR_W | Live write pointer |

## Verification
Each result has a fixed due time:
- Pointer moves, `empty`, `full` and `pushReady` follow one clock edge after the push, pop or bounds load that caused them.
- `popData` reflects the read pointer with no added register.
- `peekData` lags its address and enable by exactly one edge.

The bench changes inputs one time unit after a rising edge and lets a single edge pass. It then compares pointers and `peekData` against its own arithmetic model. Flags and `popData` are compared before the next edge, because they are functions of the pointers that were just checked. The sweep covers several windows, including a one-entry window and a window at the top of the RAM. After the sweep, every RAM index is read through the debug port.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;      // write pushData at the write pointer
    logic peekLoad;  // capture RAM word at peekAddr
    logic peekClear; // drive debug result to zero
  } cmdqStrobe_t;
endpackage

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl
  import cmdq_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int CHAN_W  = 4,
  parameter int CHAN_ID = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgLimit,
  input  logic              pushValid,
  input  logic              popEn,
  input  logic              peekEn,
  input  logic [CHAN_W-1:0] peekChan,
  output cmdqStrobe_t       strobe,
  output logic [ADDR_W-1:0] rdPtr,
  output logic [ADDR_W-1:0] wrPtr,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] limit,
  output logic              empty,
  output logic              full
);
  localparam logic [CHAN_W-1:0] MY_CHAN = CHAN_W'(CHAN_ID);

  function automatic logic [ADDR_W-1:0] stepPtr(input logic [ADDR_W-1:0] p,
                                                input logic [ADDR_W-1:0] b,
                                                input logic [ADDR_W-1:0] l);
    return (p == l) ? b : p + 1'b1;
  endfunction

  logic [ADDR_W-1:0] rdNext, wrNext;
  logic peekHit;

  assign wrNext = stepPtr(wrPtr, base, limit);
  assign rdNext = stepPtr(rdPtr, base, limit);
  assign empty  = (rdPtr == wrPtr);
  assign full   = (wrNext == rdPtr);
  assign peekHit = peekEn && (peekChan == MY_CHAN);

  always_comb begin
    strobe.wrEn      = !cfgWrite && pushValid && !full;
    strobe.peekLoad  = peekHit;
    strobe.peekClear = !peekHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      base  <= '0;
      limit <= '1;
      rdPtr <= '0;
      wrPtr <= '0;
    end else if (cfgWrite) begin
      base  <= cfgBase;
      limit <= cfgLimit;
      rdPtr <= cfgBase;
      wrPtr <= cfgBase;
    end else begin
      if (strobe.wrEn) wrPtr <= wrNext;
      if (popEn && !empty) rdPtr <= rdNext;
    end
  end
endmodule

// File: rtl/cmdq_data.sv
module cmdq_data
  import cmdq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdqStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrPtr,
  input  logic [ADDR_W-1:0] rdPtr,
  input  logic [DATA_W-1:0] pushData,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [DATA_W-1:0] popData,
  output logic [DATA_W-1:0] peekData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) ram[wrPtr] <= pushData;
  end

  assign popData = ram[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN)                 peekData <= '0;
    else if (strobe.peekLoad)  peekData <= ram[peekAddr];
    else if (strobe.peekClear) peekData <= '0;
  end
endmodule

// File: rtl/cmd_ring_fifo.sv
module cmd_ring_fifo
  import cmdq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int CHAN_W  = 4,
  parameter int CHAN_ID = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgLimit,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  output logic              pushReady,
  input  logic              popEn,
  output logic [DATA_W-1:0] popData,
  output logic              empty,
  output logic              full,
  input  logic              peekEn,
  input  logic [CHAN_W-1:0] peekChan,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [DATA_W-1:0] peekData,
  output logic [ADDR_W-1:0] peekRdPtr,
  output logic [ADDR_W-1:0] peekWrPtr
);
  cmdqStrobe_t       strobe;
  logic [ADDR_W-1:0] curBase, curLimit;

  cmdq_ctrl #(.ADDR_W(ADDR_W), .CHAN_W(CHAN_W), .CHAN_ID(CHAN_ID)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgBase(cfgBase),
    .cfgLimit(cfgLimit), .pushValid(pushValid), .popEn(popEn),
    .peekEn(peekEn), .peekChan(peekChan), .strobe(strobe),
    .rdPtr(peekRdPtr), .wrPtr(peekWrPtr), .base(curBase), .limit(curLimit),
    .empty(empty), .full(full)
  );

  cmdq_data #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrPtr(peekWrPtr),
    .rdPtr(peekRdPtr), .pushData(pushData), .peekAddr(peekAddr),
    .popData(popData), .peekData(peekData)
  );

  assign pushReady = !full;
endmodule

// File: rtl/cmdq_checker.sv
module cmdq_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrite,
  input logic [ADDR_W-1:0] cfgBase,
  input logic [ADDR_W-1:0] cfgLimit,
  input logic              pushValid,
  input logic              popEn,
  input logic              peekEn,
  input logic              empty,
  input logic              full,
  input logic [ADDR_W-1:0] peekRdPtr,
  input logic [ADDR_W-1:0] peekWrPtr,
  input logic [ADDR_W-1:0] curBase,
  input logic [ADDR_W-1:0] curLimit
);
  AST_CFG_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |-> empty);  // R9
  AST_CFG_ORDERED: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |-> cfgBase <= cfgLimit);  // R9
  AST_CFG_PTR_RESET: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> (peekRdPtr == $past(cfgBase)) && (peekWrPtr == $past(cfgBase)));  // R9
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (full && !cfgWrite) |=> $stable(peekWrPtr));  // R5
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !cfgWrite) |=> $stable(peekRdPtr));  // R6
  AST_WR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWrite && pushValid && !full && peekWrPtr == curLimit)
      |=> peekWrPtr == $past(curBase));  // R3
  AST_RD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (peekRdPtr >= curBase) && (peekRdPtr <= curLimit));  // R3
  AST_PEEK_NO_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    (peekEn && !pushValid && !popEn && !cfgWrite)
      |=> $stable(peekRdPtr) && $stable(peekWrPtr));  // R8
endmodule

bind cmd_ring_fifo cmdq_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgBase(cfgBase),
  .cfgLimit(cfgLimit), .pushValid(pushValid), .popEn(popEn),
  .peekEn(peekEn), .empty(empty), .full(full), .peekRdPtr(peekRdPtr),
  .peekWrPtr(peekWrPtr), .curBase(curBase), .curLimit(curLimit)
);

// File: tb/tb_cmd_ring_fifo.sv
module tb_cmd_ring_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int CHAN_W = 4;
  localparam int CHAN_ID = 2;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 0, rstN = 0;
  logic cfgWrite = 0, pushValid = 0, popEn = 0, peekEn = 0;
  logic [ADDR_W-1:0] cfgBase = '0, cfgLimit = '0, peekAddr = '0;
  logic [CHAN_W-1:0] peekChan = '0;
  logic [DATA_W-1:0] pushData = '0;
  logic pushReady, empty, full;
  logic [DATA_W-1:0] popData, peekData;
  logic [ADDR_W-1:0] peekRdPtr, peekWrPtr;

  int nChecks = 0, nFails = 0;
  logic [DATA_W-1:0] mMem [DEPTH];
  bit mVld [DEPTH];
  int mBase = 0, mLimit = DEPTH - 1, mRd = 0, mWr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_ring_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHAN_W(CHAN_W), .CHAN_ID(CHAN_ID)) dut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgBase(cfgBase), .cfgLimit(cfgLimit),
    .pushValid(pushValid), .pushData(pushData), .pushReady(pushReady), .popEn(popEn),
    .popData(popData), .empty(empty), .full(full), .peekEn(peekEn), .peekChan(peekChan),
    .peekAddr(peekAddr), .peekData(peekData), .peekRdPtr(peekRdPtr), .peekWrPtr(peekWrPtr)
  );

  task automatic chk(input bit ok, input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int nxt(input int p);
    return (p == mLimit) ? mBase : p + 1;
  endfunction

  task automatic chkPtrs(input string req);
    chk(peekRdPtr === ADDR_W'(mRd), req, DATA_W'(peekRdPtr), DATA_W'(mRd));
    chk(peekWrPtr === ADDR_W'(mWr), req, DATA_W'(peekWrPtr), DATA_W'(mWr));
  endtask

  task automatic step(input bit doPush, input bit doPop, input logic [DATA_W-1:0] d);
    bit expE, expF;
    expE = (mRd == mWr);
    expF = (nxt(mWr) == mRd);
    chk(empty === expE, "R4", DATA_W'(empty), DATA_W'(expE));
    chk(full === expF, "R5", DATA_W'(full), DATA_W'(expF));
    chk(pushReady === !expF, "R5", DATA_W'(pushReady), DATA_W'(!expF));
    if (!expE) chk(popData === mMem[mRd], "R2", popData, mMem[mRd]);
    pushValid = doPush; popEn = doPop; pushData = d;
    tick();
    pushValid = 0; popEn = 0;
    if (doPush && !expF) begin mMem[mWr] = d; mVld[mWr] = 1; mWr = nxt(mWr); end
    if (doPop && !expE) mRd = nxt(mRd);
    chkPtrs("R2 R3 R5 R6 R10");
  endtask

  task automatic loadCfg(input int b, input int l, input bit withTraffic);
    cfgWrite = 1; cfgBase = ADDR_W'(b); cfgLimit = ADDR_W'(l);
    pushValid = withTraffic; popEn = withTraffic; pushData = 32'hDEAD_BEEF;
    tick();
    cfgWrite = 0; pushValid = 0; popEn = 0;
    mBase = b; mLimit = l; mRd = b; mWr = b;
    chkPtrs("R9");
    chk(empty === 1'b1, "R9", DATA_W'(empty), 1);
  endtask

  task automatic peekOne(input int a, input bit rightChan);
    peekEn = 1; peekAddr = ADDR_W'(a);
    peekChan = rightChan ? CHAN_W'(CHAN_ID) : CHAN_W'(CHAN_ID + 1);
    tick();
    if (!rightChan) chk(peekData === '0, "R7", peekData, 0);
    else if (mVld[a]) chk(peekData === mMem[a], "R7", peekData, mMem[a]);
    chkPtrs("R8");
    peekEn = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++; nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    int wins [5][2];
    wins = '{'{0, 15}, '{3, 9}, '{5, 5}, '{12, 15}, '{0, 1}};
    for (int i = 0; i < DEPTH; i++) mVld[i] = 0;
    tick(); tick();
    rstN = 1;
    // R1 reset state
    chkPtrs("R1");
    chk(empty === 1'b1, "R1", DATA_W'(empty), 1);
    chk(full === 1'b0, "R1", DATA_W'(full), 0);
    chk(pushReady === 1'b1, "R1", DATA_W'(pushReady), 1);
    chk(peekData === '0, "R1", peekData, 0);
    // default window traffic before any load
    for (int i = 0; i < 20; i++) step(1'b1, i > 5, 32'h0F00_0000 + i);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, '0);

    for (int w = 0; w < 5; w++) begin
      int cap;
      loadCfg(wins[w][0], wins[w][1], w[0]);
      cap = wins[w][1] - wins[w][0];
      // fill past capacity: last push refused (R5)
      for (int i = 0; i <= cap; i++) step(1'b1, 1'b0, 32'h1000_0000 * (w + 1) + i);
      step(1'b1, 1'b0, 32'hBAD0_0000);
      for (int a = wins[w][0]; a <= wins[w][1]; a++) peekOne(a, 1'b1);
      // mixed push/pop, wraps repeatedly (R3 R10)
      for (int i = 0; i < 3 * (cap + 2); i++)
        step(i % 3 != 2, i % 2 == 0, 32'h2000_0000 * (w + 1) + i);
      // drain, then pop on empty (R6)
      for (int i = 0; i <= cap + 1; i++) step(1'b0, 1'b1, '0);
      peekOne(wins[w][0], 1'b0);
    end
    // whole RAM through debug port
    for (int a = 0; a < DEPTH; a++) peekOne(a, 1'b1);
    for (int a = 0; a < DEPTH; a += 5) peekOne(a, 1'b0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule